// File: doc/BRIEF.md
# Next Program Counter Generator

This block computes, in one combinational pass, the program counter a 16-bit processor moves to after the current instruction. Its main input is the address of the byte that follows the current instruction, called the sequential PC here. It also receives every operand a branch could need: a signed 8-bit displacement, the two bytes of a page-absolute instruction, a full 16-bit target, the accumulator and a 16-bit data pointer. A small branch-kind code selects which target wins. A separate condition input decides whether a conditional relative branch is taken.

The sequential PC is also presented unchanged as the return address, so a call sequence can push it while the selected target is loaded. The pipeline evaluates the condition elsewhere and delivers it as a single bit. Stack storage and instruction fetch live outside this block.

Top module: `nextpc_gen`

## Requirements
- R1: With kind code 0 (sequential), the next PC equals the sequential PC and the taken flag is 0.
- R2: With kind code 1 (short relative), the next PC is the sequential PC plus the 8-bit displacement read as two's complement (-128..+127), and the taken flag is 1.
- R3: With kind code 2 (page absolute), next PC bits 15:11 come from the sequential PC, bits 10:8 come from bits 7:5 of the first instruction byte, and bits 7:0 come from the second instruction byte. Bits 4:0 of the first byte have no effect. The taken flag is 1.
- R4: With kind code 3 (long absolute), the next PC equals the 16-bit absolute input and the taken flag is 1.
- R5: With kind code 4 (indexed indirect), the next PC is the data pointer plus the accumulator read as unsigned, modulo 65536, and the taken flag is 1.
- R6: With kind code 5 (conditional relative), a condition of 1 gives the R2 target with taken 1, and a condition of 0 gives the sequential PC with taken 0.
- R7: The return address output always equals the sequential PC, whatever the kind code.
- R8: Kind codes 6 and 7 are reserved and behave like sequential: the next PC equals the sequential PC and taken is 0.
- R9: The condition input has no effect on any kind code other than 5.
- R10: Relative and indexed sums wrap modulo 65536 in both directions. For example, 0xFFF0 with displacement 0x7F gives 0x006F, and 0x0005 with displacement 0x80 gives 0xFF85.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| kind_i | input | 3 | Branch kind code (0 seq, 1 short, 2 page, 3 long, 4 indexed, 5 conditional, 6-7 reserved) |
| cond_i | input | 1 | Evaluated branch condition, used only for kind 5 |
| pc_next_i | input | 16 | Address of the first byte of the following instruction |
| rel_i | input | 8 | Signed relative displacement |
| op_i | input | 8 | First byte of a page-absolute instruction |
| addr_lo_i | input | 8 | Second byte of a page-absolute instruction |
| abs_i | input | 16 | Full absolute target |
| acc_i | input | 8 | Accumulator value for indexed jumps |
| dptr_i | input | 16 | Data pointer value for indexed jumps |
| npc_o | output | 16 | Selected next program counter |
| taken_o | output | 1 | The next PC differs from sequential flow by selection |
| ret_addr_o | output | 16 | Return address for calls |

## Verification
The hardest cases to reach are the carries and borrows that cross the top of the 16-bit space. The same applies to page-absolute targets whose upper bits must survive unchanged across a 2K boundary. The stimulus drives the sequential PC right next to 0x0000, 0xFFFF and the 0x0800 page edge, paired with displacements at -128 and +127 and accumulators at 0xFF. A stepped sweep then covers the full displacement range at one base. Page targets are driven twice with different opcode low bits, so any use of those bits shows up at the output.

// File: rtl/npc_pkg.sv
package npc_pkg;

  typedef enum logic [2:0] {
    KIND_SEQ   = 3'd0,
    KIND_SHORT = 3'd1,
    KIND_PAGE  = 3'd2,
    KIND_LONG  = 3'd3,
    KIND_INDEX = 3'd4,
    KIND_COND  = 3'd5
  } br_kind_e;

endpackage

// File: rtl/npc_rel_add.sv
module npc_rel_add #(
  parameter int AW = 16,
  parameter int OW = 8
) (
  input  logic [AW-1:0] base_i,
  input  logic [OW-1:0] off_i,
  output logic [AW-1:0] tgt_o
);
  localparam int EXT = AW - OW;

  function automatic logic [AW-1:0] add_signed(input logic [AW-1:0] b,
                                               input logic [OW-1:0] o);
    logic [AW-1:0] wide;
    wide = {{EXT{o[OW-1]}}, o};
    return b + wide;
  endfunction

  assign tgt_o = add_signed(base_i, off_i);
endmodule

// File: rtl/npc_page_form.sv
module npc_page_form #(
  parameter int AW = 16,
  parameter int PW = 11,
  parameter int BW = 8
) (
  input  logic [AW-1:0] base_i,
  input  logic [BW-1:0] op_i,
  input  logic [BW-1:0] lo_i,
  output logic [AW-1:0] tgt_o
);
  localparam int UPW = PW - BW;

  function automatic logic [AW-1:0] splice(input logic [AW-1:0] b,
                                           input logic [BW-1:0] op,
                                           input logic [BW-1:0] lo);
    return {b[AW-1:PW], op[BW-1 -: UPW], lo};
  endfunction

  assign tgt_o = splice(base_i, op_i, lo_i);
endmodule

// File: rtl/npc_index_add.sv
module npc_index_add #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic [AW-1:0] ptr_i,
  input  logic [DW-1:0] idx_i,
  output logic [AW-1:0] tgt_o
);
  localparam int EXT = AW - DW;

  function automatic logic [AW-1:0] add_unsigned(input logic [AW-1:0] p,
                                                 input logic [DW-1:0] i);
    return p + {{EXT{1'b0}}, i};
  endfunction

  assign tgt_o = add_unsigned(ptr_i, idx_i);
endmodule

// File: rtl/npc_select.sv
module npc_select
  import npc_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic [2:0]    kind_i,
  input  logic          cond_i,
  input  logic [AW-1:0] seq_i,
  input  logic [AW-1:0] rel_i,
  input  logic [AW-1:0] page_i,
  input  logic [AW-1:0] abs_i,
  input  logic [AW-1:0] idx_i,
  output logic [AW-1:0] npc_o,
  output logic          taken_o
);
  always_comb begin
    npc_o   = seq_i;
    taken_o = 1'b0;
    case (kind_i)
      KIND_SHORT: begin npc_o = rel_i;  taken_o = 1'b1; end
      KIND_PAGE:  begin npc_o = page_i; taken_o = 1'b1; end
      KIND_LONG:  begin npc_o = abs_i;  taken_o = 1'b1; end
      KIND_INDEX: begin npc_o = idx_i;  taken_o = 1'b1; end
      KIND_COND: begin
        if (cond_i) begin
          npc_o   = rel_i;
          taken_o = 1'b1;
        end
      end
      default: begin
        npc_o   = seq_i;
        taken_o = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/nextpc_gen.sv
module nextpc_gen #(
  parameter int AW = 16,
  parameter int OW = 8,
  parameter int PW = 11,
  parameter int BW = 8,
  parameter int DW = 8
) (
  input  logic [2:0]    kind_i,
  input  logic          cond_i,
  input  logic [AW-1:0] pc_next_i,
  input  logic [OW-1:0] rel_i,
  input  logic [BW-1:0] op_i,
  input  logic [BW-1:0] addr_lo_i,
  input  logic [AW-1:0] abs_i,
  input  logic [DW-1:0] acc_i,
  input  logic [AW-1:0] dptr_i,
  output logic [AW-1:0] npc_o,
  output logic          taken_o,
  output logic [AW-1:0] ret_addr_o
);
  logic [AW-1:0] rel_tgt_w;
  logic [AW-1:0] page_tgt_w;
  logic [AW-1:0] idx_tgt_w;

  npc_rel_add #(.AW(AW), .OW(OW)) u_rel (
    .base_i(pc_next_i), .off_i(rel_i), .tgt_o(rel_tgt_w)
  );

  npc_page_form #(.AW(AW), .PW(PW), .BW(BW)) u_page (
    .base_i(pc_next_i), .op_i(op_i), .lo_i(addr_lo_i), .tgt_o(page_tgt_w)
  );

  npc_index_add #(.AW(AW), .DW(DW)) u_idx (
    .ptr_i(dptr_i), .idx_i(acc_i), .tgt_o(idx_tgt_w)
  );

  npc_select #(.AW(AW)) u_sel (
    .kind_i(kind_i), .cond_i(cond_i), .seq_i(pc_next_i),
    .rel_i(rel_tgt_w), .page_i(page_tgt_w), .abs_i(abs_i),
    .idx_i(idx_tgt_w), .npc_o(npc_o), .taken_o(taken_o)
  );

  assign ret_addr_o = pc_next_i;
endmodule

// File: rtl/nextpc_gen_chk.sv
module nextpc_gen_chk
  import npc_pkg::*;
#(
  parameter int AW = 16,
  parameter int PW = 11
) (
  input logic [2:0]    kind_i,
  input logic          cond_i,
  input logic [AW-1:0] pc_next_i,
  input logic [AW-1:0] abs_i,
  input logic [AW-1:0] npc_o,
  input logic          taken_o,
  input logic [AW-1:0] ret_addr_o
);
  always_comb begin
    AST_RET_IS_SEQ: assert (ret_addr_o == pc_next_i); // R7
    if (kind_i == KIND_SEQ)
      AST_SEQ_FLOW: assert (npc_o == pc_next_i && !taken_o); // R1
    if (kind_i == KIND_PAGE)
      AST_PAGE_KEEPS_TOP: assert (npc_o[AW-1:PW] == pc_next_i[AW-1:PW] && taken_o); // R3
    if (kind_i == KIND_LONG)
      AST_LONG_PASSES: assert (npc_o == abs_i && taken_o); // R4
    if (kind_i == KIND_COND && !cond_i)
      AST_COND_FALLS: assert (npc_o == pc_next_i && !taken_o); // R6
    if (kind_i > KIND_COND)
      AST_RSVD_SEQ: assert (npc_o == pc_next_i && !taken_o); // R8
  end
endmodule

bind nextpc_gen nextpc_gen_chk #(.AW(AW), .PW(PW)) u_chk (
  .kind_i(kind_i), .cond_i(cond_i), .pc_next_i(pc_next_i), .abs_i(abs_i),
  .npc_o(npc_o), .taken_o(taken_o), .ret_addr_o(ret_addr_o)
);

// File: tb/sim_nextpc_gen.sv
module sim_nextpc_gen;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic [2:0]  kind;
  logic        cond;
  logic [15:0] pc, abs_a, dptr;
  logic [7:0]  rel, op, lo, acc;
  logic [15:0] npc, ret;
  logic        taken;

  nextpc_gen u0 (
    .kind_i(kind), .cond_i(cond), .pc_next_i(pc), .rel_i(rel), .op_i(op),
    .addr_lo_i(lo), .abs_i(abs_a), .acc_i(acc), .dptr_i(dptr),
    .npc_o(npc), .taken_o(taken), .ret_addr_o(ret)
  );

  logic [15:0] exp_npc_q[$];
  logic        exp_tk_q[$];
  logic [15:0] exp_ret_q[$];
  string       tag_q[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  function automatic logic [15:0] rel_target(logic [15:0] p, logic [7:0] r);
    int s;
    s = r[7] ? int'(r) - 256 : int'(r);
    return 16'((int'(p) + s + 65536) % 65536);
  endfunction

  task automatic drive(input logic [2:0] k, input logic c, input logic [15:0] p,
                       input logic [7:0] r, input logic [7:0] o, input logic [7:0] l,
                       input logic [15:0] a, input logic [7:0] ac, input logic [15:0] d,
                       input string tag);
    logic [15:0] e;
    logic t;
    @(negedge clk);
    kind = k; cond = c; pc = p; rel = r; op = o; lo = l; abs_a = a; acc = ac; dptr = d;
    e = p; t = 1'b0;
    case (k)
      3'd1: begin e = rel_target(p, r); t = 1'b1; end
      3'd2: begin e = (p & 16'hF800) | (16'(o >> 5) << 8) | 16'(l); t = 1'b1; end
      3'd3: begin e = a; t = 1'b1; end
      3'd4: begin e = 16'((int'(d) + int'(ac)) % 65536); t = 1'b1; end
      3'd5: if (c) begin e = rel_target(p, r); t = 1'b1; end
      default: ;
    endcase
    exp_npc_q.push_back(e);
    exp_tk_q.push_back(t);
    exp_ret_q.push_back(p);
    tag_q.push_back(tag);
  endtask

  // monitor: sample at the rising edge, inputs change on the falling edge
  initial begin
    forever begin
      @(posedge clk);
      if (!rst && exp_npc_q.size() > 0) begin
        logic [15:0] en, er;
        logic et;
        string tg;
        en = exp_npc_q.pop_front();
        et = exp_tk_q.pop_front();
        er = exp_ret_q.pop_front();
        tg = tag_q.pop_front();
        checks++;
        if (npc !== en || taken !== et) begin
          errors++;
          $display("FAIL %s: npc=%h taken=%b expected npc=%h taken=%b", tg, npc, taken, en, et);
        end
        checks++;
        if (ret !== er) begin
          errors++;
          $display("FAIL R7: ret=%h expected %h", ret, er);
        end
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: expired, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    kind = 0; cond = 0; pc = 0; rel = 0; op = 0; lo = 0; abs_a = 0; acc = 0; dptr = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    drive(3'd0, 1'b1, 16'h1234, 8'h55, 8'hFF, 8'hFF, 16'hAAAA, 8'h11, 16'h2222, "R1 reset seq");
    drive(3'd1, 1'b1, 16'h0100, 8'h05, 8'h00, 8'h00, 16'h0000, 8'h00, 16'h0000, "R2 fwd");
    drive(3'd1, 1'b1, 16'h0100, 8'hFE, 8'h00, 8'h00, 16'h0000, 8'h00, 16'h0000, "R2 back");
    drive(3'd1, 1'b0, 16'hFFF0, 8'h7F, 8'h00, 8'h00, 16'h0000, 8'h00, 16'h0000, "R10 R9 wrap up");
    drive(3'd1, 1'b1, 16'h0005, 8'h80, 8'h00, 8'h00, 16'h0000, 8'h00, 16'h0000, "R10 wrap down");
    drive(3'd2, 1'b0, 16'h3ABC, 8'h00, 8'hB1, 8'h42, 16'h0000, 8'h00, 16'h0000, "R3 page");
    drive(3'd2, 1'b0, 16'h3ABC, 8'h00, 8'hBE, 8'h42, 16'h0000, 8'h00, 16'h0000, "R3 op low ignored");
    drive(3'd2, 1'b1, 16'h0800, 8'h00, 8'hF1, 8'hFF, 16'h0000, 8'h00, 16'h0000, "R3 page edge");
    drive(3'd2, 1'b1, 16'hF7FF, 8'h00, 8'h00, 8'h00, 16'h0000, 8'h00, 16'h0000, "R3 high page");
    drive(3'd3, 1'b0, 16'h4000, 8'h12, 8'h34, 8'h56, 16'hBEEF, 8'h00, 16'h0000, "R4 R9 long");
    drive(3'd4, 1'b0, 16'h0000, 8'h00, 8'h00, 8'h00, 16'h0000, 8'h10, 16'h2000, "R5 index");
    drive(3'd4, 1'b1, 16'h0000, 8'h00, 8'h00, 8'h00, 16'h0000, 8'hFF, 16'h0100, "R5 acc unsigned");
    drive(3'd4, 1'b1, 16'h0000, 8'h00, 8'h00, 8'h00, 16'h0000, 8'h20, 16'hFFF0, "R10 R5 wrap");
    drive(3'd5, 1'b1, 16'h0200, 8'h10, 8'h00, 8'h00, 16'h0000, 8'h00, 16'h0000, "R6 true");
    drive(3'd5, 1'b0, 16'h0200, 8'h10, 8'h00, 8'h00, 16'h0000, 8'h00, 16'h0000, "R6 false");
    drive(3'd5, 1'b1, 16'h0002, 8'hF0, 8'h00, 8'h00, 16'h0000, 8'h00, 16'h0000, "R6 R10 back wrap");
    drive(3'd6, 1'b1, 16'h5555, 8'h10, 8'hFF, 8'hFF, 16'h1111, 8'h01, 16'h1000, "R8 code6");
    drive(3'd7, 1'b1, 16'h6666, 8'h10, 8'hFF, 8'hFF, 16'h1111, 8'h01, 16'h1000, "R8 code7");
    drive(3'd0, 1'b0, 16'hFFFF, 8'h10, 8'h00, 8'h00, 16'h0000, 8'h00, 16'h0000, "R1 R9 cond0");
    for (int i = 0; i < 256; i += 17)
      drive(3'd1, i[0], 16'h8000, 8'(i), 8'h00, 8'h00, 16'h0000, 8'h00, 16'h0000, "R2 sweep");
    for (int k = 0; k < 8; k++)
      drive(3'(k), 1'b1, 16'hC3A5, 8'h81, 8'h6A, 8'h5A, 16'h0F0F, 8'hF0, 16'h0F10, "R7 all kinds");
    while (exp_npc_q.size() > 0) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule